// File: doc/BRIEF.md
# Prioritized Edge-Triggered Interrupt Controller

This block collects sixteen numbered interrupt sources plus one bypass input, all sampled in the block's own clock domain. A rising edge on a numbered source marks it pending in an active-low status register. Each source also has a 3-bit priority level. When that level is strictly greater than a mask threshold, the controller emits a 6-bit code naming the source. A rising edge on the bypass input always emits a fixed code. A falling edge on any input emits a clear code, which tells the processor that an interrupt has gone away.

Software reaches a small register bank through a simple 32-bit word-addressed bus. Reads return the whole word combinationally. Writes honour per-byte enables. The result stream is a single valid strobe with a code and has no back-pressure: there is no ready signal, so the consumer must take every strobe in the cycle it appears. At most one code is reported per cycle. Every edge in that cycle still updates the status register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) sets status to 0x0000FFFF, sets mask and the four level registers to 0, and holds code_valid low.
- R2: The register window is indexed by word (bus_word = byte offset / 4): status at word 0, mask at word 1, level registers 0..3 at words 4..7. Words 2 and 3 read as zero and ignore writes.
- R3: A write replaces only the bytes whose bus_be bit is set (bit b covers data bits 8b+7..8b). A read returns the full 32-bit word in the same cycle that bus_sel is high, and returns zero while bus_sel is low.
- R4: A rising edge on source s clears status bit s (0 means pending), whatever its level and the mask. Falling edges and bypass edges leave status unchanged.
- R5: The level of source s is bits [(s%4)*8+2 : (s%4)*8] of level register s/4.
- R6: A rising edge on source s produces code 16+s only when its level, treated as unsigned, is strictly greater than the full 32-bit mask value. Otherwise no code is produced for that edge.
- R7: A rising edge on the bypass input produces code 32 regardless of status, mask and levels.
- R8: A falling edge on any source or on the bypass input produces code 0 when no rising-edge code is reported in the same cycle.
- R9: When several edges occur in one cycle, the bypass rise wins, then the lowest-numbered qualifying source rise, then the clear code. The status bit of every rising source is still cleared.
- R10: An input change made before rising edge k produces a code_valid strobe after edge k+1. The strobe lasts exactly one cycle, and with no input edges code_valid stays low.
- R11: If a software write to status and a rising source edge land in the same cycle, the edge's clear of that source's bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | 16 | Numbered interrupt sources 0..15 |
| bypass_irq | input | 1 | Bypass interrupt input (code 32) |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write when high, read when low |
| bus_word | input | 3 | Word index within the register window |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| code_valid | output | 1 | One-cycle strobe for a reported code |
| code | output | 6 | Interrupt code: 0, 16..31 or 32 |

## Verification
Each input passes through one sampling register and one output register. A level change driven on a falling edge therefore shows on code_valid and code after the second rising edge that follows, and status reflects the edge after that same second edge. Register reads are combinational, and a write takes effect at the next rising edge. The bench drives every stimulus on a falling clock edge and reads results on the falling edge after the second rising edge. It checks one cycle later that the strobe has dropped, and it times the collision between a write and an edge so that both land on the same rising edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned BYTES        = REG_W / 8;
  localparam int unsigned CODE_W       = 6;
  localparam int unsigned LVL_W        = 3;
  localparam int unsigned LVL_STRIDE   = 8;
  localparam int unsigned SRC_PER_LVL  = 4;
  localparam int unsigned WIN_STATUS   = 0;
  localparam int unsigned WIN_MASK     = 1;
  localparam int unsigned WIN_LVL_BASE = 4;

  localparam logic [CODE_W-1:0] CODE_CLEAR    = 6'd0;
  localparam logic [CODE_W-1:0] CODE_SRC_BASE = 6'd16;
  localparam logic [CODE_W-1:0] CODE_BYPASS   = 6'd32;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
  } irq_event_t;

  function automatic logic [REG_W-1:0] merge_bytes(
    input logic [REG_W-1:0] old_word,
    input logic [REG_W-1:0] new_word,
    input logic [BYTES-1:0] be
  );
    logic [REG_W-1:0] res;
    res = old_word;
    for (int b = 0; b < int'(BYTES); b++) begin
      if (be[b]) res[b*8 +: 8] = new_word[b*8 +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/irq_edge_sampler.sv
module irq_edge_sampler #(
  parameter int unsigned WIDTH = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] old_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur_q[g] <= 1'b0;
        old_q[g] <= 1'b0;
      end else begin
        cur_q[g] <= raw[g];
        old_q[g] <= cur_q[g];
      end
    end
    assign rise[g] = cur_q[g] & ~old_q[g];
    assign fall[g] = ~cur_q[g] & old_q[g];
  end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned WORD_W  = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      bus_sel,
  input  logic                                      bus_we,
  input  logic [WORD_W-1:0]                         bus_word,
  input  logic [BYTES-1:0]                          bus_be,
  input  logic [REG_W-1:0]                          bus_wdata,
  output logic [REG_W-1:0]                          bus_rdata,
  input  logic [NUM_SRC-1:0]                        src_rise,
  output logic [REG_W-1:0]                          mask_q,
  output logic [NUM_SRC/SRC_PER_LVL-1:0][REG_W-1:0] lvl_q
);
  localparam int unsigned NUM_LVL = NUM_SRC / SRC_PER_LVL;
  localparam logic [REG_W-1:0] STATUS_RST = REG_W'({NUM_SRC{1'b1}});

  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] status_d;
  logic             wr_en;

  assign wr_en = bus_sel & bus_we;

  // Software write first, then edge clears override it
  always_comb begin
    status_d = status_q;
    if (wr_en && (int'(bus_word) == WIN_STATUS))
      status_d = merge_bytes(status_q, bus_wdata, bus_be);
    status_d[NUM_SRC-1:0] = status_d[NUM_SRC-1:0] & ~src_rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= STATUS_RST;
    else        status_q <= status_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '0;
    else if (wr_en && (int'(bus_word) == WIN_MASK))
      mask_q <= merge_bytes(mask_q, bus_wdata, bus_be);
  end

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n)
        lvl_q[g] <= '0;
      else if (wr_en && (int'(bus_word) == WIN_LVL_BASE + g))
        lvl_q[g] <= merge_bytes(lvl_q[g], bus_wdata, bus_be);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (int'(bus_word) == WIN_STATUS) bus_rdata = status_q;
      if (int'(bus_word) == WIN_MASK)   bus_rdata = mask_q;
      for (int i = 0; i < int'(NUM_LVL); i++) begin
        if (int'(bus_word) == int'(WIN_LVL_BASE) + i) bus_rdata = lvl_q[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [NUM_SRC-1:0]                        src_rise,
  input  logic [NUM_SRC-1:0]                        src_fall,
  input  logic                                      byp_rise,
  input  logic                                      byp_fall,
  input  logic [REG_W-1:0]                          mask_q,
  input  logic [NUM_SRC/SRC_PER_LVL-1:0][REG_W-1:0] lvl_q,
  output logic                                      code_valid,
  output logic [CODE_W-1:0]                         code
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] qual;
  logic [IDX_W-1:0]   first_idx;
  logic               any_qual;
  irq_event_t         ev_d;
  irq_event_t         ev_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [LVL_W-1:0] lvl_s;
    assign lvl_s   = lvl_q[g / SRC_PER_LVL][(g % SRC_PER_LVL) * LVL_STRIDE +: LVL_W];
    assign qual[g] = src_rise[g] && ({{(REG_W-LVL_W){1'b0}}, lvl_s} > mask_q);
  end

  always_comb begin
    first_idx = '0;
    any_qual  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (qual[i]) begin
        first_idx = IDX_W'(i);
        any_qual  = 1'b1;
      end
    end
  end

  always_comb begin
    ev_d.valid = 1'b0;
    ev_d.code  = CODE_CLEAR;
    if (byp_rise) begin
      ev_d.valid = 1'b1;
      ev_d.code  = CODE_BYPASS;
    end else if (any_qual) begin
      ev_d.valid = 1'b1;
      ev_d.code  = CODE_SRC_BASE + CODE_W'(first_idx);
    end else if (byp_fall || (|src_fall)) begin
      ev_d.valid = 1'b1;
      ev_d.code  = CODE_CLEAR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end

  assign code_valid = ev_q.valid;
  assign code       = ev_q.code;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned WORD_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_irq,
  input  logic                bypass_irq,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [WORD_W-1:0]   bus_word,
  input  logic [BYTES-1:0]    bus_be,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                code_valid,
  output logic [CODE_W-1:0]   code
);
  localparam int unsigned NUM_IN  = NUM_SRC + 1;
  localparam int unsigned NUM_LVL = NUM_SRC / SRC_PER_LVL;

  logic [NUM_IN-1:0]              rise_all;
  logic [NUM_IN-1:0]              fall_all;
  logic [REG_W-1:0]               mask_q;
  logic [NUM_LVL-1:0][REG_W-1:0]  lvl_q;

  irq_edge_sampler #(.WIDTH(NUM_IN)) u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({bypass_irq, src_irq}),
    .rise  (rise_all),
    .fall  (fall_all)
  );

  irq_prio_regs #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_word  (bus_word),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_rise  (rise_all[NUM_SRC-1:0]),
    .mask_q    (mask_q),
    .lvl_q     (lvl_q)
  );

  irq_prio_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_rise   (rise_all[NUM_SRC-1:0]),
    .src_fall   (fall_all[NUM_SRC-1:0]),
    .byp_rise   (rise_all[NUM_SRC]),
    .byp_fall   (fall_all[NUM_SRC]),
    .mask_q     (mask_q),
    .lvl_q      (lvl_q),
    .code_valid (code_valid),
    .code       (code)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_irq,
  input logic               bypass_irq,
  input logic               code_valid,
  input logic [5:0]         code
);
  logic [NUM_SRC:0] s1;
  logic [NUM_SRC:0] s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {bypass_irq, src_irq};
      s2 <= s1;
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !code_valid);

  assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> (code == 6'd0 || code == 6'd32 || (code >= 6'd16 && code <= 6'd31)));

  assert_bypass_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1[NUM_SRC] && !s2[NUM_SRC]) |=> (code_valid && code == 6'd32));

  assert_fall_only_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(s2 & ~s1)) && !(|(s1 & ~s2))) |=> (code_valid && code == 6'd0));

  assert_quiet_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s1 == s2) |=> !code_valid);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_irq    (src_irq),
  .bypass_irq (bypass_irq),
  .code_valid (code_valid),
  .code       (code)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_irq = '0;
  logic        bypass_irq = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_word = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        code_valid;
  logic [5:0]  code;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_status;
  logic [31:0] rd;

  always #2 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bypass_irq(bypass_irq),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .code_valid(code_valid), .code(code)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] w, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [2:0] w, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_word = w;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait2;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_out(input string tag, input logic v, input logic [5:0] c);
    check({tag, " valid"}, {31'd0, code_valid}, {31'd0, v});
    if (v) check({tag, " code"}, {26'd0, code}, {26'd0, c});
  endtask

  function automatic logic [31:0] lvl_word(input int r);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < 4; k++) w[k*8 +: 8] = 8'((4*r + k) % 8);
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(3'd0, rd); check("R1 status", rd, 32'h0000FFFF);
    bus_read(3'd1, rd); check("R1 mask", rd, 32'h0);
    for (int r = 0; r < 4; r++) begin
      bus_read(3'(4 + r), rd); check("R1 level", rd, 32'h0);
    end
    check_out("R1 no strobe", 1'b0, 6'd0);

    // R2 map and holes
    bus_write(3'd2, 32'hFFFFFFFF, 4'hF);
    bus_write(3'd3, 32'h12345678, 4'hF);
    bus_read(3'd2, rd); check("R2 hole 2", rd, 32'h0);
    bus_read(3'd3, rd); check("R2 hole 3", rd, 32'h0);
    bus_write(3'd1, 32'h00A5005A, 4'hF);
    bus_read(3'd1, rd); check("R2 mask rw", rd, 32'h00A5005A);
    bus_read(3'd0, rd); check("R2 status untouched", rd, 32'h0000FFFF);

    // R3 byte enables
    bus_write(3'd5, 32'h0, 4'hF);
    bus_write(3'd5, 32'hAABBCCDD, 4'b0100);
    bus_read(3'd5, rd); check("R3 byte lane", rd, 32'h00BB0000);
    bus_write(3'd5, 32'h11223344, 4'b1001);
    bus_read(3'd5, rd); check("R3 two lanes", rd, 32'h11BB0044);
    bus_sel = 1'b0; bus_word = 3'd5; #1;
    check("R3 read without select", bus_rdata, 32'h0);

    // program levels: source s gets s%8 (R5 field placement)
    for (int r = 0; r < 4; r++) bus_write(3'(4 + r), lvl_word(r), 4'hF);
    for (int r = 0; r < 4; r++) begin
      bus_read(3'(4 + r), rd); check("R5 level word", rd, lvl_word(r));
    end

    // R4 R5 R6 R8 R10 sweep of every source against every small mask
    for (int m = 0; m < 8; m++) begin
      bus_write(3'd1, 32'(m), 4'hF);
      bus_write(3'd0, 32'h0000FFFF, 4'hF);
      exp_status = 32'h0000FFFF;
      for (int s = 0; s < 16; s++) begin
        src_irq[s] = 1'b1;
        wait2;
        if ((s % 8) > m) check_out("R6 forward", 1'b1, 6'(16 + s));
        else             check_out("R6 blocked", 1'b0, 6'd0);
        exp_status[s] = 1'b0;
        bus_read(3'd0, rd); check("R4 status clear", rd, exp_status);
        @(negedge clk);
        check_out("R10 one cycle", 1'b0, 6'd0);
        src_irq[s] = 1'b0;
        wait2;
        check_out("R8 fall clear", 1'b1, 6'd0);
        bus_read(3'd0, rd); check("R4 fall keeps status", rd, exp_status);
      end
    end

    // R6 full-width mask compare
    bus_write(3'd1, 32'h00000100, 4'hF);
    src_irq[7] = 1'b1; wait2;
    check_out("R6 wide mask blocks", 1'b0, 6'd0);
    src_irq[7] = 1'b0; wait2;

    // R7 bypass
    bus_write(3'd1, 32'hFFFFFFFF, 4'hF);
    bus_write(3'd0, 32'h0000FFFF, 4'hF);
    bypass_irq = 1'b1; wait2;
    check_out("R7 bypass code", 1'b1, 6'd32);
    bus_read(3'd0, rd); check("R7 status unchanged", rd, 32'h0000FFFF);
    bypass_irq = 1'b0; wait2;
    check_out("R8 bypass fall", 1'b1, 6'd0);

    // R9 lowest qualifying source wins, all bits cleared
    bus_write(3'd1, 32'h0, 4'hF);
    src_irq = 16'h0221; wait2;
    check_out("R9 lowest qualifying", 1'b1, 6'd21);
    bus_read(3'd0, rd); check("R9 all status", rd, 32'h0000FDDE);
    src_irq = 16'h0; wait2;
    check_out("R9 clear after group", 1'b1, 6'd0);

    // R9 bypass beats a source
    bus_write(3'd0, 32'h0000FFFF, 4'hF);
    bypass_irq = 1'b1; src_irq[3] = 1'b1; wait2;
    check_out("R9 bypass wins", 1'b1, 6'd32);
    bus_read(3'd0, rd); check("R9 status with bypass", rd, 32'h0000FFF7);
    bypass_irq = 1'b0; src_irq[3] = 1'b0; wait2;

    // R9 rise beats a same-cycle fall
    src_irq[2] = 1'b1; wait2;
    src_irq[2] = 1'b0; src_irq[4] = 1'b1; wait2;
    check_out("R9 rise over fall", 1'b1, 6'd20);
    src_irq[4] = 1'b0; wait2;

    // R11 edge clear beats a same-edge status write
    bus_write(3'd0, 32'h0000FFFF, 4'hF);
    src_irq[6] = 1'b1;
    @(negedge clk);
    bus_write(3'd0, 32'h0000FFFF, 4'hF);
    bus_read(3'd0, rd); check("R11 edge wins", rd, 32'h0000FFBF);
    src_irq[6] = 1'b0; wait2;

    // R1 reset again restores everything
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    bus_read(3'd0, rd); check("R1 status after reset", rd, 32'h0000FFFF);
    bus_read(3'd4, rd); check("R1 level after reset", rd, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule